// File: doc/BRIEF.md
# Instruction Decode and Operand Select

This block is the decode step of a five-stage pipelined core with 32-bit, word-addressed instructions. From the fetched instruction word and the already incremented PC it works out which register numbers to present to a dual-read register file. It reports which register, if any, the instruction will write. It produces the control bits that later stages consume and assembles the operands that the execute stage will use. It is purely combinational: the register file read data and up to `NUM_FWD` forwarded results come in as plain inputs, and the hazard logic outside the block picks the source for each read port.

Every instruction leaves the block with three operands. Operands A and B feed the ALU. Operand C is a side value: the word to store for a store, the sign-extended offset for a conditional branch, and the jump target for a jump-and-link. The register numbers are reported as zero whenever a port or the destination is not used, so hazard comparators outside need no knowledge of instruction formats.

Top module: `instr_decode_stage`

## Requirements
- R1: Read port A takes instruction bits [23:20] for opcodes 0000, 0001, 0010, 0011, 0100 and 1010, and bits [27:24] for 0101, 1000 and 0110. Read port B takes bits [3:0] for 0000, 0001 and 1010, bits [23:20] for 0101 and 1000, and bits [27:24] for 0100. A port that is not used shows register number 0 with its used flag low.
- R2: Opcodes 0000, 0001, 0010, 0011, 1001 and 1010 name bits [27:24] as destination, and 0110 names bits [23:20]. `dest_wr` is high only when such a destination is nonzero. Otherwise `dest_reg` is 0 and `dest_wr` is low.
- R3: `alu_op` is 001 for opcode 0001 and {1, bits [5:4]} for opcode 1010, where 00 is shift left, 01 is logical shift right, 10 is rotate left and 11 is rotate right. All other opcodes give 000 (add).
- R4: `imm_ext` is always bits [19:0] sign-extended to XLEN.
- R5: Operand A is the port A value for opcodes 0000-0101, 1000 and 1010, `pc_inc` for 0110 and 1001, and zero otherwise. Operand B is the port B value for 0000, 0001, 0101, 1000 and 1010, `imm_ext` for 0010, 0011, 0100 and 1001, and zero otherwise.
- R6: Operand C is the port B value for opcode 0100, `imm_ext` for 0101 and 1000, the port A value for 0110, and zero otherwise.
- R7: `mem_rd` and `wb_mem` are high only for opcode 0011, and `mem_wr` only for 0100.
- R8: `br_eq` is high only for opcode 0101, `br_gt` only for 1000, `jump` only for 0110 and `halt` only for 0111.
- R9: A port select of 0 takes the register file data. A select of k (1..NUM_FWD) takes forwarded slot k-1, held at bits [k*XLEN-1:(k-1)*XLEN] of `fwd_data`.
- R10: A read port whose register number is 0 yields the value zero, whatever the register file data or forwarding select.
- R11: The all-zero word decodes with no register write, no memory access and no branch, jump or halt.
- R12: Opcodes 1011 to 1111 use no read port, write nothing, touch no memory and raise no branch, jump or halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Fetched instruction word |
| pc_inc | input | XLEN | Address of the instruction plus one |
| rf_rdata_a | input | XLEN | Register file data for read port A |
| rf_rdata_b | input | XLEN | Register file data for read port B |
| fwd_data | input | NUM_FWD*XLEN | Forwarded results, slot 0 in the low bits |
| fwd_sel_a | input | SEL_W | Source choice for port A (0 = register file) |
| fwd_sel_b | input | SEL_W | Source choice for port B (0 = register file) |
| rf_raddr_a | output | 4 | Register number on read port A |
| rd_a_used | output | 1 | Port A carries a real source |
| rf_raddr_b | output | 4 | Register number on read port B |
| rd_b_used | output | 1 | Port B carries a real source |
| dest_reg | output | 4 | Register to be written, 0 when none |
| dest_wr | output | 1 | Instruction writes a nonzero register |
| alu_op | output | 3 | ALU function code |
| imm_ext | output | XLEN | Sign-extended 20-bit immediate |
| op_a | output | XLEN | First ALU operand |
| op_b | output | XLEN | Second ALU operand |
| op_c | output | XLEN | Store data, branch offset or jump target |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| wb_mem | output | 1 | Write-back value comes from memory |
| br_eq | output | 1 | Branch if the two sources are equal |
| br_gt | output | 1 | Branch if source 1 is greater than source 2 |
| jump | output | 1 | Register-indirect jump with link |
| halt | output | 1 | Stop the machine |

## Verification
The hardest case to reach is the overlap of forwarding with register zero. A forwarded value must be dropped when its port names register 0, and a port that the opcode does not use must collapse to register 0 even when the instruction bits hold a nonzero number there. The sweep reaches both by crossing every opcode and every shift sub-code with register-field sets that put zero and nonzero numbers in each field, and with every pair of source selects. Forwarded slots and register file data carry distinct values, so a wrong source shows in the operand value. The immediate is swept with both sign values, and the shift sub-code lives inside the immediate bits, so the same words also cover the sign-extension and operand C paths.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned OPC_W   = 4;
   localparam int unsigned RNUM_W  = 4;
   localparam int unsigned IMM_W   = 20;
   localparam int unsigned SUB_LSB = 4;

   localparam logic [OPC_W-1:0] OPC_ADD  = 4'h0;
   localparam logic [OPC_W-1:0] OPC_NAND = 4'h1;
   localparam logic [OPC_W-1:0] OPC_ADDI = 4'h2;
   localparam logic [OPC_W-1:0] OPC_LW   = 4'h3;
   localparam logic [OPC_W-1:0] OPC_SW   = 4'h4;
   localparam logic [OPC_W-1:0] OPC_BEQ  = 4'h5;
   localparam logic [OPC_W-1:0] OPC_JALR = 4'h6;
   localparam logic [OPC_W-1:0] OPC_HALT = 4'h7;
   localparam logic [OPC_W-1:0] OPC_BGT  = 4'h8;
   localparam logic [OPC_W-1:0] OPC_LEA  = 4'h9;
   localparam logic [OPC_W-1:0] OPC_SHF  = 4'hA;

   // which instruction field feeds a register number
   typedef enum logic [1:0] {
      FLD_NONE = 2'd0,
      FLD_HI   = 2'd1,   // bits [27:24]
      FLD_MID  = 2'd2,   // bits [23:20]
      FLD_LO   = 2'd3    // bits [3:0]
   } rfld_e;

   typedef enum logic [1:0] {SA_ZERO = 2'd0, SA_RS1 = 2'd1, SA_PC = 2'd2} asel_e;
   typedef enum logic [1:0] {SB_ZERO = 2'd0, SB_RS2 = 2'd1, SB_IMM = 2'd2} bsel_e;
   typedef enum logic [1:0] {SC_ZERO = 2'd0, SC_RS1 = 2'd1, SC_RS2 = 2'd2, SC_IMM = 2'd3} csel_e;

   typedef enum logic [2:0] {
      ALU_ADD  = 3'b000,
      ALU_NAND = 3'b001,
      ALU_SLL  = 3'b100,
      ALU_SRL  = 3'b101,
      ALU_ROL  = 3'b110,
      ALU_ROR  = 3'b111
   } alu_e;

   typedef struct packed {
      rfld_e port_a;
      rfld_e port_b;
      rfld_e dest;
      asel_e a_sel;
      bsel_e b_sel;
      csel_e c_sel;
      alu_e  alu;
      logic  mem_rd;
      logic  mem_wr;
      logic  wb_mem;
      logic  br_eq;
      logic  br_gt;
      logic  jump;
      logic  halt;
   } ctrl_t;

endpackage

// File: rtl/instr_dec_fields.sv
module instr_dec_fields
   import instr_dec_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [OPC_W-1:0]   opcode,
   output logic [1:0]         sub_op,
   output logic [RNUM_W-1:0]  fld_hi,
   output logic [RNUM_W-1:0]  fld_mid,
   output logic [RNUM_W-1:0]  fld_lo,
   output logic [XLEN-1:0]    imm_ext
);

   localparam int unsigned EXT_W = XLEN - IMM_W;

   logic [IMM_W-1:0] imm_raw;

   always_comb begin
      opcode  = instr[INSTR_W-1 -: OPC_W];
      fld_hi  = instr[INSTR_W-OPC_W-1 -: RNUM_W];
      fld_mid = instr[INSTR_W-OPC_W-RNUM_W-1 -: RNUM_W];
      fld_lo  = instr[RNUM_W-1:0];
      sub_op  = instr[SUB_LSB +: 2];
      imm_raw = instr[IMM_W-1:0];
   end

   generate
      if (EXT_W == 0) begin : g_no_ext
         assign imm_ext = imm_raw;
      end else begin : g_ext
         assign imm_ext = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};
      end
   endgenerate

endmodule

// File: rtl/instr_dec_ctrl.sv
module instr_dec_ctrl
   import instr_dec_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic [1:0]       sub_op,
   output ctrl_t            ctrl
);

   always_comb begin
      ctrl = '0;
      unique case (opcode)
         OPC_ADD, OPC_NAND: begin
            ctrl.port_a = FLD_MID;
            ctrl.port_b = FLD_LO;
            ctrl.dest   = FLD_HI;
            ctrl.a_sel  = SA_RS1;
            ctrl.b_sel  = SB_RS2;
            ctrl.alu    = (opcode == OPC_NAND) ? ALU_NAND : ALU_ADD;
         end
         OPC_SHF: begin
            ctrl.port_a = FLD_MID;
            ctrl.port_b = FLD_LO;
            ctrl.dest   = FLD_HI;
            ctrl.a_sel  = SA_RS1;
            ctrl.b_sel  = SB_RS2;
            ctrl.alu    = alu_e'({1'b1, sub_op});
         end
         OPC_ADDI, OPC_LW: begin
            ctrl.port_a = FLD_MID;
            ctrl.dest   = FLD_HI;
            ctrl.a_sel  = SA_RS1;
            ctrl.b_sel  = SB_IMM;
            ctrl.mem_rd = (opcode == OPC_LW);
            ctrl.wb_mem = (opcode == OPC_LW);
         end
         OPC_SW: begin
            ctrl.port_a = FLD_MID;
            ctrl.port_b = FLD_HI;
            ctrl.a_sel  = SA_RS1;
            ctrl.b_sel  = SB_IMM;
            ctrl.c_sel  = SC_RS2;
            ctrl.mem_wr = 1'b1;
         end
         OPC_BEQ, OPC_BGT: begin
            ctrl.port_a = FLD_HI;
            ctrl.port_b = FLD_MID;
            ctrl.a_sel  = SA_RS1;
            ctrl.b_sel  = SB_RS2;
            ctrl.c_sel  = SC_IMM;
            ctrl.br_eq  = (opcode == OPC_BEQ);
            ctrl.br_gt  = (opcode == OPC_BGT);
         end
         OPC_JALR: begin
            ctrl.port_a = FLD_HI;
            ctrl.dest   = FLD_MID;
            ctrl.a_sel  = SA_PC;
            ctrl.c_sel  = SC_RS1;
            ctrl.jump   = 1'b1;
         end
         OPC_LEA: begin
            ctrl.dest   = FLD_HI;
            ctrl.a_sel  = SA_PC;
            ctrl.b_sel  = SB_IMM;
         end
         OPC_HALT: begin
            ctrl.halt   = 1'b1;
         end
         default: begin
            ctrl = '0;
         end
      endcase
   end

endmodule

// File: rtl/instr_dec_src.sv
module instr_dec_src
   import instr_dec_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NUM_FWD    = 3,
   parameter int unsigned SEL_W      = 2,
   parameter bit          ZERO_FORCE = 1'b1
) (
   input  logic [RNUM_W-1:0]       raddr,
   input  logic [XLEN-1:0]         rf_data,
   input  logic [NUM_FWD*XLEN-1:0] fwd_data,
   input  logic [SEL_W-1:0]        sel,
   output logic [XLEN-1:0]         value
);

   logic [XLEN-1:0] picked;

   always_comb begin
      picked = rf_data;
      for (int k = 1; k <= NUM_FWD; k++) begin
         if (int'(sel) == k) picked = fwd_data[(k-1)*XLEN +: XLEN];
      end
   end

   generate
      if (ZERO_FORCE) begin : g_zero
         assign value = (raddr == '0) ? '0 : picked;
      end else begin : g_pass
         assign value = picked;
      end
   endgenerate

endmodule

// File: rtl/instr_decode_stage.sv
module instr_decode_stage
   import instr_dec_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NUM_FWD    = 3,
   parameter int unsigned SEL_W      = $clog2(NUM_FWD + 1),
   parameter bit          ZERO_FORCE = 1'b1
) (
   input  logic [INSTR_W-1:0]      instr,
   input  logic [XLEN-1:0]         pc_inc,
   input  logic [XLEN-1:0]         rf_rdata_a,
   input  logic [XLEN-1:0]         rf_rdata_b,
   input  logic [NUM_FWD*XLEN-1:0] fwd_data,
   input  logic [SEL_W-1:0]        fwd_sel_a,
   input  logic [SEL_W-1:0]        fwd_sel_b,
   output logic [RNUM_W-1:0]       rf_raddr_a,
   output logic                    rd_a_used,
   output logic [RNUM_W-1:0]       rf_raddr_b,
   output logic                    rd_b_used,
   output logic [RNUM_W-1:0]       dest_reg,
   output logic                    dest_wr,
   output logic [2:0]              alu_op,
   output logic [XLEN-1:0]         imm_ext,
   output logic [XLEN-1:0]         op_a,
   output logic [XLEN-1:0]         op_b,
   output logic [XLEN-1:0]         op_c,
   output logic                    mem_rd,
   output logic                    mem_wr,
   output logic                    wb_mem,
   output logic                    br_eq,
   output logic                    br_gt,
   output logic                    jump,
   output logic                    halt
);

   localparam int unsigned N_PORTS = 2;

   // elaboration-time parameter checks
   generate
      if (XLEN < IMM_W + 1) begin : g_bad_xlen
         $error("XLEN must exceed the immediate width");
      end
      if (NUM_FWD < 1) begin : g_bad_nfwd
         $error("NUM_FWD must be at least 1");
      end
      if (SEL_W != $clog2(NUM_FWD + 1)) begin : g_bad_selw
         $error("SEL_W must be clog2(NUM_FWD+1)");
      end
   endgenerate

   logic [OPC_W-1:0]  opcode;
   logic [1:0]        sub_op;
   logic [RNUM_W-1:0] fld_hi, fld_mid, fld_lo;
   ctrl_t             ctrl;

   instr_dec_fields #(.XLEN(XLEN)) u_fields (
      .instr   (instr),
      .opcode  (opcode),
      .sub_op  (sub_op),
      .fld_hi  (fld_hi),
      .fld_mid (fld_mid),
      .fld_lo  (fld_lo),
      .imm_ext (imm_ext)
   );

   instr_dec_ctrl u_ctrl (
      .opcode (opcode),
      .sub_op (sub_op),
      .ctrl   (ctrl)
   );

   function automatic logic [RNUM_W-1:0] pick_fld(rfld_e f, logic [RNUM_W-1:0] hi,
                                                   logic [RNUM_W-1:0] mid, logic [RNUM_W-1:0] lo);
      case (f)
         FLD_HI:  return hi;
         FLD_MID: return mid;
         FLD_LO:  return lo;
         default: return '0;
      endcase
   endfunction

   // per-port register numbers and resolved values
   rfld_e             port_fld [N_PORTS];
   logic [RNUM_W-1:0] port_addr[N_PORTS];
   logic [XLEN-1:0]   port_rf  [N_PORTS];
   logic [SEL_W-1:0]  port_sel [N_PORTS];
   logic [XLEN-1:0]   port_val [N_PORTS];

   always_comb begin
      port_fld[0] = ctrl.port_a;
      port_fld[1] = ctrl.port_b;
      port_rf[0]  = rf_rdata_a;
      port_rf[1]  = rf_rdata_b;
      port_sel[0] = fwd_sel_a;
      port_sel[1] = fwd_sel_b;
   end

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_port
         assign port_addr[p] = pick_fld(port_fld[p], fld_hi, fld_mid, fld_lo);

         instr_dec_src #(
            .XLEN       (XLEN),
            .NUM_FWD    (NUM_FWD),
            .SEL_W      (SEL_W),
            .ZERO_FORCE (ZERO_FORCE)
         ) u_src (
            .raddr    (port_addr[p]),
            .rf_data  (port_rf[p]),
            .fwd_data (fwd_data),
            .sel      (port_sel[p]),
            .value    (port_val[p])
         );
      end
   endgenerate

   logic [RNUM_W-1:0] dest_num;

   always_comb begin
      rf_raddr_a = port_addr[0];
      rf_raddr_b = port_addr[1];
      rd_a_used  = (ctrl.port_a != FLD_NONE);
      rd_b_used  = (ctrl.port_b != FLD_NONE);

      dest_num   = pick_fld(ctrl.dest, fld_hi, fld_mid, fld_lo);
      dest_wr    = (ctrl.dest != FLD_NONE) && (dest_num != '0);
      dest_reg   = dest_wr ? dest_num : '0;

      alu_op     = ctrl.alu;
      mem_rd     = ctrl.mem_rd;
      mem_wr     = ctrl.mem_wr;
      wb_mem     = ctrl.wb_mem;
      br_eq      = ctrl.br_eq;
      br_gt      = ctrl.br_gt;
      jump       = ctrl.jump;
      halt       = ctrl.halt;
   end

   // operand steering
   always_comb begin
      unique case (ctrl.a_sel)
         SA_RS1:  op_a = port_val[0];
         SA_PC:   op_a = pc_inc;
         default: op_a = '0;
      endcase
      unique case (ctrl.b_sel)
         SB_RS2:  op_b = port_val[1];
         SB_IMM:  op_b = imm_ext;
         default: op_b = '0;
      endcase
      unique case (ctrl.c_sel)
         SC_RS1:  op_c = port_val[0];
         SC_RS2:  op_c = port_val[1];
         SC_IMM:  op_c = imm_ext;
         default: op_c = '0;
      endcase
   end

endmodule

// File: rtl/instr_decode_stage_chk.sv
module instr_decode_stage_chk
   import instr_dec_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input logic [INSTR_W-1:0] instr,
   input logic [RNUM_W-1:0]  rf_raddr_a,
   input logic               rd_a_used,
   input logic [RNUM_W-1:0]  rf_raddr_b,
   input logic               rd_b_used,
   input logic [RNUM_W-1:0]  dest_reg,
   input logic               dest_wr,
   input logic [XLEN-1:0]    imm_ext,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic               wb_mem,
   input logic               br_eq,
   input logic               br_gt,
   input logic               jump,
   input logic               halt
);

   logic reserved;
   assign reserved = (instr[INSTR_W-1 -: OPC_W] > OPC_SHF);

   always_comb begin
      a_r1_unused_a: assert (rd_a_used || rf_raddr_a == '0)
         else $error("port A number nonzero while unused");
      a_r1_unused_b: assert (rd_b_used || rf_raddr_b == '0)
         else $error("port B number nonzero while unused");
      a_r2_dest_nonzero: assert (!dest_wr || dest_reg != '0)
         else $error("write flagged for register zero");
      a_r2_idle_dest: assert (dest_wr || dest_reg == '0)
         else $error("destination shown without write");
      a_r4_sign_fill: assert (imm_ext[XLEN-1:IMM_W] == {(XLEN-IMM_W){instr[IMM_W-1]}})
         else $error("immediate upper bits not a sign copy");
      a_r7_mem_excl: assert (!(mem_rd && mem_wr))
         else $error("memory read and write together");
      a_r7_store_no_dest: assert (!mem_wr || !dest_wr)
         else $error("store also writes a register");
      a_r7_wb_needs_load: assert (!wb_mem || mem_rd)
         else $error("memory write-back without a load");
      a_r8_flow_onehot: assert ($onehot0({br_eq, br_gt, jump, halt}))
         else $error("more than one flow control bit");
      a_r12_reserved_idle: assert (!reserved ||
            !(dest_wr || mem_rd || mem_wr || br_eq || br_gt || jump || halt || rd_a_used || rd_b_used))
         else $error("reserved opcode has an effect");
   end

endmodule

bind instr_decode_stage instr_decode_stage_chk #(.XLEN(XLEN)) u_chk (
   .instr      (instr),
   .rf_raddr_a (rf_raddr_a),
   .rd_a_used  (rd_a_used),
   .rf_raddr_b (rf_raddr_b),
   .rd_b_used  (rd_b_used),
   .dest_reg   (dest_reg),
   .dest_wr    (dest_wr),
   .imm_ext    (imm_ext),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .wb_mem     (wb_mem),
   .br_eq      (br_eq),
   .br_gt      (br_gt),
   .jump       (jump),
   .halt       (halt)
);

// File: tb/instr_decode_stage_bench.sv
module instr_decode_stage_bench;

   localparam int XLEN = 32;
   localparam int NF   = 3;
   localparam int SW   = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [31:0]      instr;
   logic [XLEN-1:0]  pc_inc, rf_rdata_a, rf_rdata_b;
   logic [NF*XLEN-1:0] fwd_data;
   logic [SW-1:0]    fwd_sel_a, fwd_sel_b;
   logic [3:0]       rf_raddr_a, rf_raddr_b, dest_reg;
   logic             rd_a_used, rd_b_used, dest_wr;
   logic [2:0]       alu_op;
   logic [XLEN-1:0]  imm_ext, op_a, op_b, op_c;
   logic             mem_rd, mem_wr, wb_mem, br_eq, br_gt, jump, halt;

   instr_decode_stage #(.XLEN(XLEN), .NUM_FWD(NF)) u_instr_decode_stage (
      .instr(instr), .pc_inc(pc_inc), .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
      .fwd_data(fwd_data), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
      .rf_raddr_a(rf_raddr_a), .rd_a_used(rd_a_used), .rf_raddr_b(rf_raddr_b),
      .rd_b_used(rd_b_used), .dest_reg(dest_reg), .dest_wr(dest_wr), .alu_op(alu_op),
      .imm_ext(imm_ext), .op_a(op_a), .op_b(op_b), .op_c(op_c), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .wb_mem(wb_mem), .br_eq(br_eq), .br_gt(br_gt), .jump(jump), .halt(halt)
   );

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [XLEN-1:0] src_val(input logic [3:0] a, input logic [SW-1:0] s,
                                               input logic [XLEN-1:0] rf);
      if (a == 4'd0) return '0;                       // R10
      if (s == 0) return rf;                          // R9
      return fwd_data[(int'(s)-1)*XLEN +: XLEN];
   endfunction

   task automatic run_vec(input logic [31:0] w, input logic [SW-1:0] sa, input logic [SW-1:0] sb,
                          input logic [XLEN-1:0] rfa, input logic [XLEN-1:0] rfb);
      logic [3:0] op, f1, f2, s2, aa, ab, d;
      logic ua, ub, wd, e_mrd, e_mwr, e_beq, e_bgt, e_jmp, e_hlt;
      logic [2:0] e_alu;
      logic [XLEN-1:0] e_imm, v1, v2, e_a, e_b, e_c;
      logic e_dw;
      string t_ctl, t_a, t_b;
      @(negedge clk);
      instr = w; fwd_sel_a = sa; fwd_sel_b = sb; rf_rdata_a = rfa; rf_rdata_b = rfb;
      #1;
      op = w[31:28]; f1 = w[27:24]; f2 = w[23:20]; s2 = w[3:0];
      e_imm = {{(XLEN-20){w[19]}}, w[19:0]};
      ua = 0; ub = 0; wd = 0; aa = 0; ab = 0; d = 0; e_alu = 3'b000;
      e_mrd = 0; e_mwr = 0; e_beq = 0; e_bgt = 0; e_jmp = 0; e_hlt = 0;
      case (op)
         4'h0, 4'h1, 4'hA: begin ua = 1; aa = f2; ub = 1; ab = s2; wd = 1; d = f1; end
         4'h2, 4'h3:       begin ua = 1; aa = f2; wd = 1; d = f1; end
         4'h4:             begin ua = 1; aa = f2; ub = 1; ab = f1; end
         4'h5, 4'h8:       begin ua = 1; aa = f1; ub = 1; ab = f2; end
         4'h6:             begin ua = 1; aa = f1; wd = 1; d = f2; end
         4'h9:             begin wd = 1; d = f1; end
         default: ;
      endcase
      if (op == 4'h1) e_alu = 3'b001;
      if (op == 4'hA) e_alu = {1'b1, w[5:4]};
      e_mrd = (op == 4'h3); e_mwr = (op == 4'h4);
      e_beq = (op == 4'h5); e_bgt = (op == 4'h8); e_jmp = (op == 4'h6); e_hlt = (op == 4'h7);
      v1 = src_val(aa, sa, rfa);
      v2 = src_val(ab, sb, rfb);
      case (op)
         4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8, 4'hA: e_a = v1;
         4'h6, 4'h9: e_a = pc_inc;
         default:    e_a = '0;
      endcase
      case (op)
         4'h0, 4'h1, 4'h5, 4'h8, 4'hA: e_b = v2;
         4'h2, 4'h3, 4'h4, 4'h9:       e_b = e_imm;
         default:                      e_b = '0;
      endcase
      case (op)
         4'h4:       e_c = v2;
         4'h5, 4'h8: e_c = e_imm;
         4'h6:       e_c = v1;
         default:    e_c = '0;
      endcase
      e_dw  = wd && (d != 4'd0);
      t_ctl = (op > 4'hA) ? "R12" : "R7/R8";
      t_a   = (ua && aa == 0) ? "R10" : ((sa != 0) ? "R9" : "R5");
      t_b   = (ub && ab == 0) ? "R10" : ((sb != 0) ? "R9" : "R5");
      chk((op > 4'hA) ? "R12" : "R1", "read ports", {rf_raddr_a, rd_a_used, rf_raddr_b, rd_b_used},
          {ua ? aa : 4'd0, ua, ub ? ab : 4'd0, ub});
      chk((op > 4'hA) ? "R12" : "R2", "dest", {dest_reg, dest_wr}, {e_dw ? d : 4'd0, e_dw});
      chk("R3", "alu_op", alu_op, e_alu);
      chk("R4", "imm_ext", imm_ext, e_imm);
      chk(t_a, "op_a", op_a, e_a);
      chk(t_b, "op_b", op_b, e_b);
      chk("R6", "op_c", op_c, e_c);
      chk(t_ctl, "mem", {mem_rd, mem_wr, wb_mem}, {e_mrd, e_mwr, e_mrd});
      chk(t_ctl, "flow", {br_eq, br_gt, jump, halt}, {e_beq, e_bgt, e_jmp, e_hlt});
   endtask

   initial begin
      #800000;
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] rsets [4][3];
      logic [13:0] ihi [2];
      int v;
      rsets[0] = '{4'd0, 4'd0, 4'd0};
      rsets[1] = '{4'd5, 4'd9, 4'd3};
      rsets[2] = '{4'd15, 4'd0, 4'd12};
      rsets[3] = '{4'd0, 4'd7, 4'd0};
      ihi[0] = 14'h0A5C;
      ihi[1] = 14'h3FF1;
      instr = '0; fwd_sel_a = '0; fwd_sel_b = '0;
      pc_inc = 32'h0000_1235;
      rf_rdata_a = 32'h1111_1111; rf_rdata_b = 32'h2222_2222;
      fwd_data = {32'hC3C3_0003, 32'hB2B2_0002, 32'hA1A1_0001};
      // R11: initial all-zero word
      #3;
      chk("R11", "noop dest", {dest_reg, dest_wr}, 5'd0);
      chk("R11", "noop mem", {mem_rd, mem_wr, wb_mem}, 3'd0);
      chk("R11", "noop flow", {br_eq, br_gt, jump, halt}, 4'd0);
      chk("R11", "noop operands", {op_a, op_b}, 64'd0);
      v = 0;
      for (int op = 0; op < 16; op++)
         for (int sub = 0; sub < 4; sub++)
            for (int rs = 0; rs < 4; rs++)
               for (int ih = 0; ih < 2; ih++)
                  for (int sa = 0; sa < 4; sa++)
                     for (int sb = 0; sb < 4; sb++) begin
                        v++;
                        pc_inc = 32'h0000_1000 + v;
                        run_vec({op[3:0], rsets[rs][0], rsets[rs][1], ihi[ih], sub[1:0], rsets[rs][2]},
                                sa[1:0], sb[1:0], 32'h5A00_0000 ^ v, 32'h00A5_0000 ^ (v << 1));
                     end
      // R11 and R12 explicit words
      run_vec(32'h0000_0000, 2'd1, 2'd2, 32'h7777_7777, 32'h8888_8888);
      chk("R11", "noop write", dest_wr, 1'b0);
      run_vec(32'hFFFF_FFFF, 2'd3, 2'd3, 32'h7777_7777, 32'h8888_8888);
      chk("R12", "reserved ports", {rd_a_used, rd_b_used, dest_wr}, 3'd0);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule